// File: doc/BRIEF.md
# Three-Phase Bootstrap Charge Sequencer

This block sits between the commutation logic of a three-phase bridge and the gate drivers. For each half-bridge phase it receives the requested high-side and low-side drive. It also receives two comparator results for that phase's bootstrap capacitor: one says the voltage is above the turn-on limit, the other says it is above the turn-off limit. From these it produces the gate enables that actually reach the drivers.

A high-side request is granted only when the capacitor holds enough charge. If it does not, the phase first runs a charge cycle, which turns on its own low-side switch to refill the capacitor. The high side is handed over once the turn-on comparator reports success. Charge is also watched while the high side conducts. A drop below the turn-off limit sends the phase back into a charge cycle.

Every charge cycle is bounded by a timeout. A phase whose capacitor does not recover in time latches its own fault bit and holds both of its switches off until a fault-clear pulse arrives. The other phases keep running.

Top module: `bstrap_seq`

## Requirements
- R1: After reset, every gate enable and every fault bit is 0 and each phase is idle.
- R2: An idle phase that sees its high-side request with the turn-on comparator high drives its high-side enable to 1 (low-side 0) from the next clock edge.
- R3: An idle phase that sees its high-side request with the turn-on comparator low enters a charge cycle at the next edge: low-side enable 1, high-side enable 0.
- R4: During a charge cycle, a high turn-on comparator ends the cycle at the next edge with high-side enable 1 and low-side enable 0.
- R5: While the high side conducts with the request held, a low turn-off comparator starts a new charge cycle at the next edge, and the charge timer restarts from zero for that cycle.
- R6: If a charge cycle has not ended after TIMEOUT_CYCLES clock edges (the low-side enable having been high for exactly TIMEOUT_CYCLES cycles), the phase's fault bit becomes 1 and both of its enables become 0.
- R7: Faults are per phase: fault bit i belongs to phase i, and a fault in one phase leaves the other phases' behaviour unchanged.
- R8: A faulted phase ignores all requests and comparator inputs with its enables held at 0 until fault_clr is 1 at a clock edge, after which the phase is idle with its fault bit 0.
- R9: The high-side and low-side enables of one phase are never 1 together.
- R10: In an idle phase the low-side request passes combinationally to the low-side enable when no high-side request is present; a simultaneous high-side request masks it.
- R11: Removing the high-side request during a charge cycle or during high-side conduction returns the phase to idle at the next edge with both enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_clr | input | 1 | Clears all latched phase faults when high at a clock edge |
| hs_req | input | NUM_PHASES | Requested high-side drive per phase |
| ls_req | input | NUM_PHASES | Requested low-side drive per phase |
| cap_above_on | input | NUM_PHASES | Bootstrap voltage above turn-on limit, per phase |
| cap_above_off | input | NUM_PHASES | Bootstrap voltage above turn-off limit, per phase |
| hs_en | output | NUM_PHASES | High-side gate enable per phase |
| ls_en | output | NUM_PHASES | Low-side gate enable per phase |
| phase_fault | output | NUM_PHASES | Latched charge-timeout fault per phase |

## Verification
The hardest situation to reach is a second charge cycle that starts from high-side conduction. It must get a fresh timeout window and not the remainder of the first one. The bench gets there by starting a short charge cycle, granting the high side, and then dropping the turn-off comparator. It then holds the phase in the new cycle for TIMEOUT_CYCLES minus one more edges. A timer that had not restarted would fault early. The timeout itself is reached with a reduced TIMEOUT_CYCLES parameter. While one phase sits faulted, the bench drives requests into it and runs the other phases normally.

// File: rtl/bstrap_pkg.sv
package bstrap_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CHARGE = 2'd1,
      PH_HIGH   = 2'd2,
      PH_FAULT  = 2'd3
   } phase_state_t;

endpackage

// File: rtl/bstrap_timer.sv
module bstrap_timer #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == LAST);

endmodule

// File: rtl/bstrap_phase.sv
module bstrap_phase
   import bstrap_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_clr,
   input  logic hs_req,
   input  logic ls_req,
   input  logic above_on,
   input  logic above_off,
   output logic hs_en,
   output logic ls_en,
   output logic fault
);
   phase_state_t state_q, state_d;
   logic         start_chg;
   logic         tmr_expired;

   always_comb begin
      state_d   = state_q;
      start_chg = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (hs_req) begin
               if (above_on) begin
                  state_d = PH_HIGH;
               end else begin
                  state_d   = PH_CHARGE;
                  start_chg = 1'b1;
               end
            end
         end
         PH_CHARGE: begin
            if (!hs_req)          state_d = PH_IDLE;
            else if (above_on)    state_d = PH_HIGH;
            else if (tmr_expired) state_d = PH_FAULT;
         end
         PH_HIGH: begin
            if (!hs_req) begin
               state_d = PH_IDLE;
            end else if (!above_off) begin
               state_d   = PH_CHARGE;
               start_chg = 1'b1;
            end
         end
         PH_FAULT: begin
            if (fault_clr) state_d = PH_IDLE;
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PH_IDLE;
      else        state_q <= state_d;
   end

   bstrap_timer #(.LIMIT(TIMEOUT_CYCLES)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (start_chg),
      .run     (state_q == PH_CHARGE),
      .expired (tmr_expired)
   );

   assign hs_en = (state_q == PH_HIGH);
   assign ls_en = (state_q == PH_CHARGE) ||
                  ((state_q == PH_IDLE) && ls_req && !hs_req);
   assign fault = (state_q == PH_FAULT);

endmodule

// File: rtl/bstrap_seq.sv
module bstrap_seq #(
   parameter int NUM_PHASES     = 3,
   parameter int TIMEOUT_CYCLES = 1000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fault_clr,
   input  logic [NUM_PHASES-1:0] hs_req,
   input  logic [NUM_PHASES-1:0] ls_req,
   input  logic [NUM_PHASES-1:0] cap_above_on,
   input  logic [NUM_PHASES-1:0] cap_above_off,
   output logic [NUM_PHASES-1:0] hs_en,
   output logic [NUM_PHASES-1:0] ls_en,
   output logic [NUM_PHASES-1:0] phase_fault
);

   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("bstrap_seq: NUM_PHASES must be at least 1");
   end
   if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
      $error("bstrap_seq: TIMEOUT_CYCLES must be at least 2");
   end

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      bstrap_phase #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) phase_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .fault_clr (fault_clr),
         .hs_req    (hs_req[p]),
         .ls_req    (ls_req[p]),
         .above_on  (cap_above_on[p]),
         .above_off (cap_above_off[p]),
         .hs_en     (hs_en[p]),
         .ls_en     (ls_en[p]),
         .fault     (phase_fault[p])
      );
   end

endmodule

// File: rtl/bstrap_seq_chk.sv
module bstrap_seq_chk #(
   parameter int NUM_PHASES = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  fault_clr,
   input logic [NUM_PHASES-1:0] hs_req,
   input logic [NUM_PHASES-1:0] ls_req,
   input logic [NUM_PHASES-1:0] cap_above_on,
   input logic [NUM_PHASES-1:0] cap_above_off,
   input logic [NUM_PHASES-1:0] hs_en,
   input logic [NUM_PHASES-1:0] ls_en,
   input logic [NUM_PHASES-1:0] phase_fault
);

   for (genvar i = 0; i < NUM_PHASES; i++) begin : g_chk
      assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !(hs_en[i] && ls_en[i]));

      assert_hs_needs_charge_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hs_en[i]) |-> $past(cap_above_on[i]));

      assert_recharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (hs_en[i] && hs_req[i] && !cap_above_off[i]) |=> (ls_en[i] && !hs_en[i]));

      assert_fault_from_charge_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(phase_fault[i]) |-> ($past(ls_en[i]) && $past(hs_req[i])));

      assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
         phase_fault[i] |-> (!hs_en[i] && !ls_en[i]));

      assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (phase_fault[i] && !fault_clr) |=> phase_fault[i]);

      assert_drop_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
         ((hs_en[i] || (ls_en[i] && hs_req[i])) && !phase_fault[i] && !hs_req[i])
            |=> !hs_en[i]);
   end

endmodule

bind bstrap_seq bstrap_seq_chk #(.NUM_PHASES(NUM_PHASES)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .fault_clr     (fault_clr),
   .hs_req        (hs_req),
   .ls_req        (ls_req),
   .cap_above_on  (cap_above_on),
   .cap_above_off (cap_above_off),
   .hs_en         (hs_en),
   .ls_en         (ls_en),
   .phase_fault   (phase_fault)
);

// File: tb/bstrap_seq_tb.sv
`timescale 1ns/1ps
module bstrap_seq_tb_top;
   localparam int NP  = 3;
   localparam int TMO = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fault_clr = 1'b0;
   logic [NP-1:0] hs_req = '0, ls_req = '0, on_c = '0, off_c = '0;
   logic [NP-1:0] hs_en, ls_en, phase_fault;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   bstrap_seq #(.NUM_PHASES(NP), .TIMEOUT_CYCLES(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr),
      .hs_req(hs_req), .ls_req(ls_req),
      .cap_above_on(on_c), .cap_above_off(off_c),
      .hs_en(hs_en), .ls_en(ls_en), .phase_fault(phase_fault));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      chk("R9 overlap", 32'(hs_en & ls_en), 32'd0);
   endtask

   task automatic drive_edge();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 hs_en", 32'(hs_en), 0);
      chk("R1 ls_en", 32'(ls_en), 0);
      chk("R1 fault", 32'(phase_fault), 0);
   endtask

   task automatic t_direct(input int p);
      drive_edge();
      on_c[p] = 1; off_c[p] = 1; hs_req[p] = 1;
      step();
      chk("R2 hs_en", 32'(hs_en[p]), 1);
      chk("R2 ls_en", 32'(ls_en[p]), 0);
      drive_edge();
      hs_req[p] = 0;
      step();
      chk("R11 hs off", 32'(hs_en[p]), 0);
      chk("R11 ls off", 32'(ls_en[p]), 0);
   endtask

   task automatic t_charge(input int p);
      drive_edge();
      on_c[p] = 0; off_c[p] = 0; hs_req[p] = 1;
      step();
      chk("R3 ls_en", 32'(ls_en[p]), 1);
      chk("R3 hs_en", 32'(hs_en[p]), 0);
      for (int k = 0; k < 3; k++) step();
      drive_edge();
      on_c[p] = 1; off_c[p] = 1;
      step();
      chk("R4 hs_en", 32'(hs_en[p]), 1);
      chk("R4 ls_en", 32'(ls_en[p]), 0);
      drive_edge();
      on_c[p] = 0; off_c[p] = 0;
      step();
      chk("R5 recharge ls", 32'(ls_en[p]), 1);
      chk("R5 recharge hs", 32'(hs_en[p]), 0);
      for (int k = 1; k < TMO; k++) step();
      chk("R5 timer restarted", 32'(phase_fault[p]), 0);
      chk("R5 still charging", 32'(ls_en[p]), 1);
      drive_edge();
      on_c[p] = 1; off_c[p] = 1;
      step();
      chk("R4 hs after recharge", 32'(hs_en[p]), 1);
      drive_edge();
      on_c[p] = 0; off_c[p] = 0;
      step();
      chk("R5 charge again", 32'(ls_en[p]), 1);
      drive_edge();
      hs_req[p] = 0;
      step();
      chk("R11 drop in charge", 32'({hs_en[p], ls_en[p]}), 0);
   endtask

   task automatic t_timeout(input int p, input int q);
      drive_edge();
      on_c[p] = 0; off_c[p] = 0; hs_req[p] = 1;
      step();
      for (int k = 1; k < TMO; k++) begin
         step();
         if (ls_en[p] !== 1'b1 || phase_fault[p] !== 1'b0)
            chk("R6 early end", 32'({ls_en[p], phase_fault[p]}), 32'b10);
      end
      chk("R6 charging at TMO-1", 32'(ls_en[p]), 1);
      step();
      chk("R6 fault", 32'(phase_fault[p]), 1);
      chk("R6 enables off", 32'({hs_en[p], ls_en[p]}), 0);
      chk("R7 other faults", 32'(phase_fault & ~(NP'(1) << p)), 0);
      drive_edge();
      on_c[p] = 1; off_c[p] = 1; ls_req[p] = 1;
      on_c[q] = 1; off_c[q] = 1; hs_req[q] = 1;
      step();
      chk("R7 other phase runs", 32'(hs_en[q]), 1);
      for (int k = 0; k < 3; k++) step();
      chk("R8 fault held", 32'(phase_fault[p]), 1);
      chk("R8 inputs ignored", 32'({hs_en[p], ls_en[p]}), 0);
      drive_edge();
      fault_clr = 1;
      step();
      chk("R8 cleared", 32'(phase_fault[p]), 0);
      chk("R8 idle after clear", 32'({hs_en[p], ls_en[p]}), 0);
      drive_edge();
      fault_clr = 0;
      step();
      chk("R2 after clear", 32'(hs_en[p]), 1);
      drive_edge();
      hs_req = '0; ls_req = '0;
      step();
   endtask

   task automatic t_ls_pass(input int p);
      drive_edge();
      ls_req[p] = 1; hs_req[p] = 0; on_c[p] = 1; off_c[p] = 1;
      #1;
      chk("R10 ls pass", 32'(ls_en[p]), 1);
      drive_edge();
      hs_req[p] = 1;
      #1;
      chk("R10 hs masks ls", 32'(ls_en[p]), 0);
      step();
      chk("R2 hs with ls req", 32'(hs_en[p]), 1);
      drive_edge();
      hs_req[p] = 0; ls_req[p] = 0;
      step();
   endtask

   initial begin
      #1;
      t_reset();
      repeat (3) @(posedge clk);
      drive_edge();
      rst_n = 1;
      step();
      t_reset();
      t_direct(0);
      t_charge(1);
      t_timeout(2, 0);
      t_ls_pass(1);
      t_direct(2);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule